// File: doc/BRIEF.md
# Dual-Select Stereo Serial Receiver

This block receives one serial audio stream carrying left and right channel words, one after the other, on shared serial clock, serial data and word-select lines. Inside are two identical peripheral-mode capture channels wired to the same three lines. The left channel treats the word-select line as active-high. The right channel treats it as active-low. At any moment exactly one channel is enabled, so consecutive words go to alternate channels without any dedicated audio framing logic.

The serial lines are asynchronous to the system clock. A two-stage synchronizer brings them into the system clock domain, and an edge detector turns the synchronized serial clock into a one-cycle sampling pulse. Each channel runs a three-state controller:

- `RX_IDLE`: the channel's select is inactive.
- `RX_SHIFT`: the select is active and bits are being gathered.
- `RX_FULL`: a complete word has been taken, and the channel waits for its select to go inactive.

The transitions are:

- IDLE to SHIFT on select active.
- SHIFT to FULL on the last bit of a word.
- SHIFT to IDLE on an early select drop, which discards the partial word.
- FULL to IDLE on select inactive.

A completed word is latched into the channel's output register together with a one-cycle valid strobe.

Top module: `dual_select_audio_rx`

## Requirements
- R1: While reset is asserted and after its release with no serial activity, both word outputs are zero and both valid strobes are low.
- R2: Bits clocked while word-select is high are captured by the left channel. Bits clocked while it is low are captured by the right channel. The two valid strobes are never high in the same cycle.
- R3: A word is WORD_W bits (2 to 16) sampled on rising edges of the serial clock, most significant bit first. The first bit sampled lands in the word's top bit.
- R4: If a channel's select goes inactive before WORD_W bits have been sampled, the partial word is discarded and produces no strobe. The next word on that channel starts from its first bit.
- R5: Each completed word produces a valid strobe on its channel that is high for exactly one system clock cycle.
- R6: A channel's word output changes only in the cycle its valid strobe is high, and otherwise holds its last captured word.
- R7: Serial clock edges after the WORD_W-th bit, while the select stays active, are ignored. No second word is captured until the select has gone inactive and active again.
- R8: Counting the system clock edge that first samples the final rising serial clock edge as edge 0, the word and valid outputs change after edge 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from the audio source (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first (asynchronous) |
| word_sel | input | 1 | Word select: high for left words, low for right words (asynchronous) |
| left_word | output | WORD_W | Last completed left-channel word |
| left_valid | output | 1 | One-cycle strobe when left_word is updated |
| right_word | output | WORD_W | Last completed right-channel word |
| right_valid | output | 1 | One-cycle strobe when right_word is updated |

## Verification
The hardest states to reach from the ports are a channel abandoned partway through a word and a channel sitting in its full state while the serial clock keeps running. Ordinary stereo frames never produce either one. The stimulus therefore sends deliberately truncated words on each channel before toggling word-select, and also keeps serial clock edges coming after a complete word while the select is held. Every clock is compared against a behavioural model that delays the pin history by the synchronizer depth. This exposes any extra strobe, stale bit or shifted latency.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    // Per-channel capture controller states
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,  // channel select inactive
        RX_SHIFT = 2'd1,  // select active, gathering bits
        RX_FULL  = 2'd2   // word taken, waiting for select to drop
    } rx_state_e;

    // Channel index convention used by the top level
    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;
    localparam int N_CH     = 2;

endpackage

// File: rtl/serial_in_sync.sv
module serial_in_sync #(
    parameter int N_SIG  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] async_i,
    output logic [N_SIG-1:0] sync_o
);

    logic [N_SIG-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sclk_edge_det.sv
module sclk_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic rise_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sck_i;
        end
    end

    assign rise_o = sck_i & ~prev_q;

    // A rising edge needs the clock to have been low the cycle before
    p_rise_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/chan_capture.sv
module chan_capture
    import audio_rx_pkg::*;
#(
    parameter int WORD_W          = 16,
    parameter bit SEL_ACTIVE_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              data_i,
    input  logic              rise_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);

    localparam int              CNT_W    = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;
    logic              act;
    logic              take;
    logic              last_bit;

    // Effective select: polarity chosen per channel
    if (SEL_ACTIVE_HIGH) begin : g_sel_hi
        assign act = sel_i;
    end else begin : g_sel_lo
        assign act = ~sel_i;
    end

    assign take     = act && rise_i && (state_q != RX_FULL);
    assign last_bit = take && (cnt_q == LAST_IDX);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (act) begin
                    state_d = last_bit ? RX_FULL : RX_SHIFT;
                end
            end
            RX_SHIFT: begin
                if (!act) begin
                    state_d = RX_IDLE;
                end else if (last_bit) begin
                    state_d = RX_FULL;
                end
            end
            RX_FULL: begin
                if (!act) begin
                    state_d = RX_IDLE;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (!act) begin
            cnt_q <= '0;
        end else if (take) begin
            shreg_q <= {shreg_q[WORD_W-2:0], data_i};
            cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= last_bit;
            if (last_bit) begin
                word_o <= {shreg_q[WORD_W-2:0], data_i};
            end
        end
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

    p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (cnt_q == '0) && (state_q == RX_IDLE));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(word_o));

    p_full_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_FULL) && act |=> !valid_o);

endmodule

// File: rtl/dual_select_audio_rx.sv
module dual_select_audio_rx
    import audio_rx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              word_sel,
    output logic [WORD_W-1:0] left_word,
    output logic              left_valid,
    output logic [WORD_W-1:0] right_word,
    output logic              right_valid
);

    localparam int N_SER = 3;
    localparam int B_SCK = 0;
    localparam int B_DAT = 1;
    localparam int B_SEL = 2;

    logic [N_SER-1:0]  ser_raw;
    logic [N_SER-1:0]  ser_sync;
    logic              sck_rise;
    logic [WORD_W-1:0] word_arr  [N_CH];
    logic              valid_arr [N_CH];

    assign ser_raw[B_SCK] = ser_clk;
    assign ser_raw[B_DAT] = ser_data;
    assign ser_raw[B_SEL] = word_sel;

    serial_in_sync #(
        .N_SIG  (N_SER),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ser_raw),
        .sync_o  (ser_sync)
    );

    sclk_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (ser_sync[B_SCK]),
        .rise_o (sck_rise)
    );

    // Left channel sees select active-high, right channel active-low
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        chan_capture #(
            .WORD_W          (WORD_W),
            .SEL_ACTIVE_HIGH (ch == CH_LEFT)
        ) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (ser_sync[B_SEL]),
            .data_i  (ser_sync[B_DAT]),
            .rise_i  (sck_rise),
            .word_o  (word_arr[ch]),
            .valid_o (valid_arr[ch])
        );
    end

    assign left_word   = word_arr[CH_LEFT];
    assign left_valid  = valid_arr[CH_LEFT];
    assign right_word  = word_arr[CH_RIGHT];
    assign right_valid = valid_arr[CH_RIGHT];

    p_one_channel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_valid && right_valid));

endmodule

// File: tb/dual_select_audio_rx_tb.sv
module dual_select_audio_rx_tb_top;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic word_sel = 1'b0;
    logic [W-1:0] left_word, right_word;
    logic left_valid, right_valid;

    always #10 clk = ~clk;  // 50 MHz

    dual_select_audio_rx #(.WORD_W(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .word_sel    (word_sel),
        .left_word   (left_word),
        .left_valid  (left_valid),
        .right_word  (right_word),
        .right_valid (right_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_rise = 0;
    int exp_cnt [2];
    int got_cnt [2];

    // Behavioural reference: pin history, per-channel counters
    logic         h_sck [4];
    logic         h_dat [4];
    logic         h_sel [4];
    int           m_cnt   [2];
    bit           m_full  [2];
    logic [W-1:0] m_acc   [2];
    logic [W-1:0] m_word  [2];
    bit           m_valid [2];

    task automatic check(bit ok, string req, logic [31:0] actv, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                h_sck[i] = 1'b0; h_dat[i] = 1'b0; h_sel[i] = 1'b0;
            end
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = 0; m_full[c] = 1'b0; m_acc[c] = '0;
                m_word[c] = '0; m_valid[c] = 1'b0;
            end
        end else begin
            for (int i = 3; i > 0; i--) begin
                h_sck[i] = h_sck[i-1]; h_dat[i] = h_dat[i-1]; h_sel[i] = h_sel[i-1];
            end
            h_sck[0] = ser_clk; h_dat[0] = ser_data; h_sel[0] = word_sel;
            for (int c = 0; c < 2; c++) begin
                bit act;
                act = (c == 0) ? h_sel[2] : !h_sel[2];
                m_valid[c] = 1'b0;
                if (!act) begin
                    m_cnt[c] = 0;
                    m_full[c] = 1'b0;
                end else if (h_sck[2] && !h_sck[3] && !m_full[c]) begin
                    m_acc[c] = {m_acc[c][W-2:0], h_dat[2]};
                    m_cnt[c]++;
                    if (m_cnt[c] == W) begin
                        m_word[c] = m_acc[c];
                        m_valid[c] = 1'b1;
                        m_full[c] = 1'b1;
                        m_cnt[c] = 0;
                    end
                end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(left_valid === m_valid[0], "R5 left strobe", 32'(left_valid), 32'(m_valid[0]));
            check(right_valid === m_valid[1], "R5 right strobe", 32'(right_valid), 32'(m_valid[1]));
            check(left_word === m_word[0], "R6 left word", 32'(left_word), 32'(m_word[0]));
            check(right_word === m_word[1], "R6 right word", 32'(right_word), 32'(m_word[1]));
            check(!(left_valid && right_valid), "R2 exclusive strobes",
                  32'({left_valid, right_valid}), 32'h0);
            if (left_valid) got_cnt[0]++;
            if (right_valid) got_cnt[1]++;
            if (left_valid || right_valid)
                check(cyc - last_rise == 2, "R8 latency", 32'(cyc - last_rise), 32'd2);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Send the top nb bits of v, MSB first
    task automatic send_bits(logic [W-1:0] v, int nb);
        for (int i = W - 1; i >= W - nb; i--) begin
            ser_clk = 1'b0;
            ser_data = v[i];
            tick(2);
            ser_clk = 1'b1;
            last_rise = cyc + 1;
            tick(2);
        end
        ser_clk = 1'b0;
        tick(2);
    endtask

    task automatic frame(logic [W-1:0] lw, logic [W-1:0] rw);
        word_sel = 1'b1;
        tick(2);
        send_bits(lw, W);
        exp_cnt[0]++;
        word_sel = 1'b0;
        tick(2);
        send_bits(rw, W);
        exp_cnt[1]++;
        tick(4);
        check(left_word == lw, "R3 left capture", 32'(left_word), 32'(lw));
        check(right_word == rw, "R2 R3 right capture", 32'(right_word), 32'(rw));
    endtask

    task automatic check_counts(string req);
        check(got_cnt[0] == exp_cnt[0], req, 32'(got_cnt[0]), 32'(exp_cnt[0]));
        check(got_cnt[1] == exp_cnt[1], req, 32'(got_cnt[1]), 32'(exp_cnt[1]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        exp_cnt[0] = 0; exp_cnt[1] = 0; got_cnt[0] = 0; got_cnt[1] = 0;
        tick(3);
        // R1: reset state
        check(left_word == '0, "R1 left word in reset", 32'(left_word), 32'h0);
        check(right_word == '0, "R1 right word in reset", 32'(right_word), 32'h0);
        check(!left_valid && !right_valid, "R1 strobes in reset",
              32'({left_valid, right_valid}), 32'h0);
        rst_n = 1'b1;
        tick(5);
        check(left_word == '0 && right_word == '0, "R1 idle after reset",
              {left_word, right_word}, 32'h0);

        // R2 R3: stereo frames with varied patterns
        frame(16'hA5C3, 16'h3C5A);
        frame(16'hFFFF, 16'h0000);
        frame(16'h8001, 16'h7FFE);
        frame(16'h1234, 16'hFEDC);
        check_counts("R5 one strobe per word");

        // R4: left word cut short, then a full frame
        word_sel = 1'b1;
        tick(2);
        send_bits(16'hFFFF, 5);
        word_sel = 1'b0;
        tick(3);
        check_counts("R4 partial left dropped");
        frame(16'h0F0F, 16'h5555);

        // R4: right word cut short, then a full frame
        send_bits(16'hFFFF, 9);
        word_sel = 1'b1;
        tick(3);
        check_counts("R4 partial right dropped");
        check(right_word == 16'h5555, "R4 right word kept", 32'(right_word), 32'h5555);
        frame(16'hC0DE, 16'h0001);

        // R7: extra edges after a full left word
        word_sel = 1'b1;
        tick(2);
        send_bits(16'h9A3B, W);
        exp_cnt[0]++;
        send_bits(16'hFFFF, 4);
        send_bits(16'h0000, W);
        check_counts("R7 extra edges ignored");
        check(left_word == 16'h9A3B, "R7 left word kept", 32'(left_word), 32'h9A3B);
        word_sel = 1'b0;
        tick(2);
        send_bits(16'h2468, W);
        exp_cnt[1]++;
        tick(4);
        check(right_word == 16'h2468, "R2 right after extra", 32'(right_word), 32'h2468);

        // R6: idle period, outputs hold
        tick(20);
        check(left_word == 16'h9A3B, "R6 left hold", 32'(left_word), 32'h9A3B);
        check_counts("R5 final counts");
        finish_run();
    end

endmodule